// File: doc/BRIEF.md
# S/PDIF Transmit Channel-Status Buffer

This block holds the channel-status block for the two subframe channels of an S/PDIF transmitter and gives the framer one status bit for each subframe it sends. The host writes bytes into a staging image. A routing bit chooses which channel's staging image receives each write. At a block boundary, marked by the Z-preamble strobe, both staging images are loaded into the active images. The framer reads from the active images only.

The active images are sent again and again with no host action. A frame counter steps once per frame and wraps at the end of the block. A hold input stops the load at block boundaries, so the host can finish rewriting both channels before any of the new data goes out. A duplicate option makes both subframes carry the channel A status, which covers the usual case where the two channels match.

Top module: `spdif_cs_tx_buf`

## Requirements
- R1: After reset, `cs_vld` and `cs_bit` are 0, both staging images and both active images are all zeros, and the frame index is 0.
- R2: A write with `wr_addr` from 0 to 23 stores `wr_data` as that byte of one staging image: channel A when `sel_b`=0, channel B when `sel_b`=1. The other channel's staging image does not change.
- R3: A write with `wr_addr` from 24 to 31 changes neither staging image.
- R4: When `blk_start` is high and `copy_hold` is 0, both staging images are loaded into their active images and the frame index returns to 0.
- R5: When `blk_start` is high and `copy_hold` is 1, both active images keep their contents, but the frame index still returns to 0.
- R6: Writes to a staging image do not change the transmitted bits until the next load allowed by R4.
- R7: One cycle after `sub_stb`, `cs_vld` is 1 and `cs_bit` is bit f of the active image of channel `sub_chan` (0 = A, 1 = B). Here f is the current frame index, and bit f is bit f%8 of byte f/8. In every other cycle `cs_vld` is 0.
- R8: When `same_ab` is 1, channel B subframes carry the channel A active bit.
- R9: The frame index steps up by one after each channel B subframe strobe. It wraps from 191 to 0, so the block repeats without `blk_start`.
- R10: When a host write falls in the same cycle as an allowed load, the load takes the staging content from before the write. The written byte stays in staging and goes out after the next load.
- R11: A `sub_stb` in the same cycle as `blk_start` is dropped: no `cs_vld` pulse follows and the frame index does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | ADDR_W (5) | Byte index in the staging image |
| wr_data | input | BYTE_W (8) | Byte written |
| sel_b | input | 1 | Write routing: 0 = channel A staging, 1 = channel B staging |
| same_ab | input | 1 | Send the channel A status on both subframes |
| copy_hold | input | 1 | Block the staging-to-active load |
| blk_start | input | 1 | Z-preamble strobe that marks frame 0 |
| sub_stb | input | 1 | Subframe strobe that requests one status bit |
| sub_chan | input | 1 | Channel of the subframe: 0 = A, 1 = B |
| cs_bit | output | 1 | Channel-status bit for the requested subframe |
| cs_vld | output | 1 | One-cycle pulse when `cs_bit` is valid |

## Verification
Two of the block's functions can land in the same cycle. First, a host write can meet the staging-to-active load: the bench drives a write in the same cycle as `blk_start`. It then checks that the block sent right after carries the old byte and that the block after the next load carries the new one. Second, a subframe strobe can meet the block-start strobe: the bench drives both together. It checks that no `cs_vld` pulse appears and that the next subframe reads frame 0.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
   typedef enum logic {
      CS_CH_A = 1'b0,
      CS_CH_B = 1'b1
   } cs_chan_e;

   localparam int CS_NUM_CHAN = 2;
endpackage

// File: rtl/cs_stage_store.sv
module cs_stage_store #(
   parameter int NBYTES = 24,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [BYTE_W-1:0]        wr_data,
   output logic [NBYTES*BYTE_W-1:0] img
);
   localparam logic [ADDR_W:0] LIMIT = NBYTES[ADDR_W:0];

   logic [NBYTES-1:0][BYTE_W-1:0] mem_q;
   logic                          addr_ok;

   generate
      if (NBYTES < (1 << ADDR_W)) begin : g_range_chk
         assign addr_ok = ({1'b0, wr_addr} < LIMIT);
      end else begin : g_full_map
         assign addr_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (wr_en && addr_ok) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign img = mem_q;

   assert_unmapped_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_addr} >= LIMIT)) |=> $stable(img));
   assert_idle_store_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(img));
endmodule

// File: rtl/cs_active_bank.sv
module cs_active_bank #(
   parameter int BITS = 192
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] stage_img,
   output logic [BITS-1:0] act_img
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_img <= '0;
      end else if (load) begin
         act_img <= stage_img;
      end
   end

   assert_no_change_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act_img));
endmodule

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
   parameter int FRAMES = 192,
   parameter int FRM_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   output logic [FRM_W-1:0] frame
);
   localparam logic [FRM_W-1:0] LAST = FRM_W'(FRAMES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
      end else if (restart) begin
         frame <= '0;
      end else if (adv) begin
         frame <= (frame == LAST) ? '0 : frame + 1'b1;
      end
   end

   assert_frame_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !restart && frame == LAST) |=> (frame == '0));
   assert_frame_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (frame == '0));
   assert_frame_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame <= LAST);
endmodule

// File: rtl/spdif_cs_tx_buf.sv
module spdif_cs_tx_buf #(
   parameter int FRAMES = 192,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = $clog2(FRAMES / BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              sel_b,
   input  logic              same_ab,
   input  logic              copy_hold,
   input  logic              blk_start,
   input  logic              sub_stb,
   input  logic              sub_chan,
   output logic              cs_bit,
   output logic              cs_vld
);
   import spdif_cs_pkg::*;

   localparam int NBYTES = FRAMES / BYTE_W;
   localparam int FRM_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1;

   generate
      if (FRAMES % BYTE_W != 0) begin : g_bad_frames
         $error("FRAMES must be a multiple of BYTE_W");
      end
      if ((1 << ADDR_W) < NBYTES) begin : g_bad_addr
         $error("ADDR_W too narrow for the staging image");
      end
   endgenerate

   logic [FRAMES-1:0] stage_img [CS_NUM_CHAN];
   logic [FRAMES-1:0] act_img   [CS_NUM_CHAN];
   logic [FRM_W-1:0]  frame;
   logic              load;
   logic              adv;
   cs_chan_e          wr_chan;
   cs_chan_e          rd_chan;

   assign wr_chan = cs_chan_e'(sel_b);
   assign rd_chan = (same_ab || (sub_chan == 1'b0)) ? CS_CH_A : CS_CH_B;
   assign load    = blk_start && !copy_hold;
   assign adv     = sub_stb && sub_chan && !blk_start;

   generate
      for (genvar ch = 0; ch < CS_NUM_CHAN; ch++) begin : g_chan
         logic chan_wr;
         assign chan_wr = wr_en && (wr_chan == cs_chan_e'(ch));

         cs_stage_store #(
            .NBYTES(NBYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
         ) u_stage (
            .clk(clk), .rst_n(rst_n), .wr_en(chan_wr),
            .wr_addr(wr_addr), .wr_data(wr_data), .img(stage_img[ch])
         );

         cs_active_bank #(.BITS(FRAMES)) u_active (
            .clk(clk), .rst_n(rst_n), .load(load),
            .stage_img(stage_img[ch]), .act_img(act_img[ch])
         );
      end
   endgenerate

   cs_frame_ctr #(.FRAMES(FRAMES), .FRM_W(FRM_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .restart(blk_start), .adv(adv), .frame(frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_vld <= 1'b0;
         cs_bit <= 1'b0;
      end else begin
         cs_vld <= sub_stb && !blk_start;
         if (sub_stb && !blk_start) begin
            cs_bit <= act_img[rd_chan][frame];
         end
      end
   end

   assert_hold_blocks_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && copy_hold) |=> ($stable(act_img[0]) && $stable(act_img[1])));
   assert_collide_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_stb && blk_start) |=> !cs_vld);
   assert_vld_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_vld |-> $past(sub_stb));
   assert_vld_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_stb && !blk_start) |=> cs_vld);
endmodule

// File: tb/spdif_cs_tx_buf_bench.sv
module spdif_cs_tx_buf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int FRAMES     = 192;
   localparam int NB         = FRAMES / 8;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       sel_b = 1'b0;
   logic       same_ab = 1'b0;
   logic       copy_hold = 1'b0;
   logic       blk_start = 1'b0;
   logic       sub_stb = 1'b0;
   logic       sub_chan = 1'b0;
   logic       cs_bit;
   logic       cs_vld;

   int n_chk = 0;
   int n_bad = 0;
   int frm = 0;
   logic [7:0] stg [2][NB];
   logic [7:0] act [2][NB];

   always #(CLK_PERIOD / 2) clk = ~clk;

   spdif_cs_tx_buf u_spdif_cs_tx_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sel_b(sel_b), .same_ab(same_ab),
      .copy_hold(copy_hold), .blk_start(blk_start), .sub_stb(sub_stb),
      .sub_chan(sub_chan), .cs_bit(cs_bit), .cs_vld(cs_vld)
   );

   task automatic chk(input logic ok, input string req, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (frame %0d)", req, actv, expv, frm);
      end
   endtask

   function automatic void mdl_write(input int ch, input int a, input logic [7:0] d);
      if (a < NB) stg[ch][a] = d;
   endfunction

   task automatic host_wr(input logic ch, input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; sel_b = ch; wr_addr = 5'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_write(int'(ch), a, d);
   endtask

   // Z-preamble strobe, optionally with a coinciding write (R10) or subframe (R11)
   task automatic blk(input logic with_wr, input logic ch, input int a,
                      input logic [7:0] d, input logic with_sub);
      @(negedge clk);
      blk_start = 1'b1;
      if (with_wr) begin wr_en = 1'b1; sel_b = ch; wr_addr = 5'(a); wr_data = d; end
      if (with_sub) begin sub_stb = 1'b1; sub_chan = 1'b0; end
      @(negedge clk);
      blk_start = 1'b0; wr_en = 1'b0; sub_stb = 1'b0;
      if (!copy_hold) begin
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < NB; i++) act[c][i] = stg[c][i];
      end
      if (with_wr) mdl_write(int'(ch), a, d);
      frm = 0;
      if (with_sub) chk(cs_vld == 1'b0, "R11 dropped strobe", int'(cs_vld), 0);
   endtask

   task automatic subframe(input logic ch, input string req);
      int src;
      logic e;
      @(negedge clk);
      sub_stb = 1'b1; sub_chan = ch;
      @(negedge clk);
      sub_stb = 1'b0;
      src = (same_ab || !ch) ? 0 : 1;
      e = act[src][frm / 8][frm % 8];
      chk(cs_vld == 1'b1, {req, " R7 valid"}, int'(cs_vld), 1);
      chk(cs_bit == e, req, int'(cs_bit), int'(e));
      if (ch) frm = (frm + 1) % FRAMES;
   endtask

   task automatic run_frames(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         subframe(1'b0, req);
         subframe(1'b1, req);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < NB; i++) begin stg[c][i] = '0; act[c][i] = '0; end
      repeat (3) @(negedge clk);
      chk(cs_vld == 1'b0, "R1 vld in reset", int'(cs_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_vld == 1'b0 && cs_bit == 1'b0, "R1 outputs after reset", int'({cs_vld, cs_bit}), 0);
      run_frames(FRAMES, "R1 zero block");

      // R2: distinct patterns per channel
      for (int i = 0; i < NB; i++) host_wr(1'b0, i, 8'((i * 37 + 5) ^ 8'h5A));
      for (int i = 0; i < NB; i++) host_wr(1'b1, i, 8'((i * 91 + 17) ^ 8'hC3));
      run_frames(FRAMES, "R6 staged not sent");
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      run_frames(FRAMES, "R2 R4 R7 loaded block");
      run_frames(FRAMES, "R9 repeat without strobe");

      // R3: unmapped addresses
      for (int a = NB; a < 32; a++) begin
         host_wr(1'b0, a, 8'hFF);
         host_wr(1'b1, a, 8'hFF);
      end
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      run_frames(FRAMES, "R3 unmapped ignored");

      // R5: hold blocks the load; restart still happens mid-block
      copy_hold = 1'b1;
      for (int i = 0; i < NB; i++) host_wr(1'b0, i, 8'(~i));
      run_frames(50, "R5 pre-restart");
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      run_frames(FRAMES, "R5 held block");
      copy_hold = 1'b0;
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      run_frames(FRAMES, "R4 released load");

      // R8: duplicate channel A
      same_ab = 1'b1;
      run_frames(FRAMES, "R8 same for both");
      same_ab = 1'b0;

      // R10: write coincides with load
      host_wr(1'b1, 3, 8'h00);
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      blk(1'b1, 1'b1, 3, 8'hFF, 1'b0);
      run_frames(32, "R10 old byte sent");
      blk(1'b0, 1'b0, 0, 8'h00, 1'b0);
      run_frames(32, "R10 new byte sent");

      // R11: subframe with block start
      run_frames(20, "R11 pre");
      blk(1'b0, 1'b0, 0, 8'h00, 1'b1);
      run_frames(4, "R11 frame 0 after drop");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule